// File: doc/BRIEF.md
# CAN Receive Acceptance Filter

This block picks the mailbox that will store a frame just taken off the CAN bus. On a one-cycle frame-valid strobe it compares the received identifier and its format bit with the identifier and format bit of every mailbox at once. The comparison is done through an acceptance mask. Only mailboxes that are enabled and set to receive take part. The hit flag and the winning mailbox index are registered and appear on the next clock.

Two masks are used. A global mask serves every mailbox. A private local mask replaces it for the last mailbox only. Each mask has an identifier field and a separate bit that decides whether the format bit must match. Standard and extended frames are both filtered, and data frames and remote frames are treated the same way. Decoding the frame, storing its data, overrun handling and interrupts are done by other blocks.

Top module: `can_acc_filter`

## Requirements
- R1: While rst_ni is low, and after it is released, hit_o is 0 and idx_o is 0 until the first frame-valid strobe.
- R2: A mailbox can be selected only if its enable bit is 1 and its direction bit is 1, where 1 means receive. A disabled mailbox is never selected, and neither is a transmit mailbox.
- R3: A mask identifier bit of 1 makes the frame bit and the mailbox bit at that position take part in the comparison. A mask bit of 0 makes that position don't care. For mailboxes 0 to N_MBOX-2, the global mask is used.
- R4: Mailbox N_MBOX-1 (31 by default) is compared through the local mask identifier and the local format bit, and the global mask has no effect on it.
- R5: Identifiers are 29 bits wide. A standard frame (format bit 0) carries its 11-bit base identifier in bits 28:18, and only those bits are compared. An extended frame (format bit 1) compares all 29 bits.
- R6: When the mask format bit used for a mailbox is 1, the frame format bit must equal that mailbox's format bit. When it is 0, the format bits are not compared.
- R7: The remote-frame bit has no effect on the hit flag or on the index.
- R8: When several mailboxes match, the lowest index is selected.
- R9: hit_o is 1 in the cycle after a strobe exactly when a mailbox matched, and it is 0 in every other cycle.
- R10: idx_o is updated only in the cycle after a strobe. It takes the winning index on a hit and 0 on a miss, and keeps its value until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frm_vld_i | input | 1 | One-cycle strobe marking a received frame |
| frm_id_i | input | 29 | Received identifier; the base identifier is in bits 28:18 |
| frm_ext_i | input | 1 | Received format bit: 1 for extended, 0 for standard |
| frm_rtr_i | input | 1 | Received remote-frame bit |
| mb_id_i | input | N_MBOX*29 | Mailbox identifiers; mailbox k is in bits k*29 +: 29 |
| mb_ext_i | input | N_MBOX | Mailbox format bits |
| mb_en_i | input | N_MBOX | Mailbox enable bits |
| mb_rx_i | input | N_MBOX | Mailbox direction bits; 1 means receive |
| gmask_id_i | input | 29 | Global mask identifier |
| gmask_ext_i | input | 1 | Global mask format bit |
| lmask_id_i | input | 29 | Local mask identifier for the last mailbox |
| lmask_ext_i | input | 1 | Local mask format bit for the last mailbox |
| hit_o | output | 1 | A mailbox was chosen for the last strobed frame |
| idx_o | output | $clog2(N_MBOX) | Index of the chosen mailbox |

## Verification
The assertions run on every cycle. They check that a reported hit always names a mailbox that was enabled and set to receive, and that this mailbox was the lowest set bit of the match vector. They also check that hit_o appears only after a strobe and agrees with whether any match was present, and that idx_o does not change between strobes.

The match vector itself, and therefore the mask semantics, can only be shown by the bench's scenarios. These cover how standard and extended frames are compared, the global and local format bits, the local mask taking the place of the global one for the last mailbox, and the remote-frame bit having no effect.

// File: rtl/can_acc_pkg.sv
package can_acc_pkg;
  localparam int unsigned ID_W   = 29;
  localparam int unsigned BASE_W = 11;
  localparam int unsigned EXT_W  = ID_W - BASE_W;

  typedef logic [ID_W-1:0] can_id_t;

  typedef struct packed {
    can_id_t id;
    logic    ext;
  } acc_mask_t;
endpackage

// File: rtl/can_acc_cmp.sv
module can_acc_cmp
  import can_acc_pkg::*;
(
  input  can_id_t   frm_id_i,
  input  logic      frm_ext_i,
  input  can_id_t   mb_id_i,
  input  logic      mb_ext_i,
  input  logic      mb_en_i,
  input  logic      mb_rx_i,
  input  acc_mask_t mask_i,
  output logic      match_o
);
  can_id_t care;
  can_id_t diff;
  logic    fmt_ok;

  always_comb begin
    care = mask_i.id;
    // standard frames: extension bits are never compared
    if (!frm_ext_i) care[EXT_W-1:0] = '0;
    diff   = (frm_id_i ^ mb_id_i) & care;
    fmt_ok = !mask_i.ext || (frm_ext_i == mb_ext_i);
  end

  assign match_o = mb_en_i & mb_rx_i & fmt_ok & ~|diff;
endmodule

// File: rtl/can_acc_prio.sv
module can_acc_prio #(
  parameter int unsigned N     = 32,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    any_o = |req_i;
    idx_o = '0;
    // descending scan: the last assignment is the lowest set bit
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/can_acc_filter.sv
module can_acc_filter
  import can_acc_pkg::*;
#(
  parameter int unsigned N_MBOX = 32,
  localparam int unsigned IDX_W = (N_MBOX > 1) ? $clog2(N_MBOX) : 1,
  localparam int unsigned LOCAL_MB = N_MBOX - 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   frm_vld_i,
  input  logic [ID_W-1:0]        frm_id_i,
  input  logic                   frm_ext_i,
  input  logic                   frm_rtr_i,
  input  logic [N_MBOX*ID_W-1:0] mb_id_i,
  input  logic [N_MBOX-1:0]      mb_ext_i,
  input  logic [N_MBOX-1:0]      mb_en_i,
  input  logic [N_MBOX-1:0]      mb_rx_i,
  input  logic [ID_W-1:0]        gmask_id_i,
  input  logic                   gmask_ext_i,
  input  logic [ID_W-1:0]        lmask_id_i,
  input  logic                   lmask_ext_i,
  output logic                   hit_o,
  output logic [IDX_W-1:0]       idx_o
);
  acc_mask_t          gmask;
  acc_mask_t          lmask;
  logic [N_MBOX-1:0]  match_vec;
  logic               any_match;
  logic [IDX_W-1:0]   win_idx;
  logic               hit_q;
  logic [IDX_W-1:0]   idx_q;
  logic               rtr_unused;

  // remote frames are filtered exactly like data frames
  assign rtr_unused = frm_rtr_i;

  assign gmask = '{id: gmask_id_i, ext: gmask_ext_i};
  assign lmask = '{id: lmask_id_i, ext: lmask_ext_i};

  for (genvar k = 0; k < N_MBOX; k++) begin : g_mb
    acc_mask_t sel_mask;
    if (k == LOCAL_MB) begin : g_loc
      assign sel_mask = lmask;
    end else begin : g_glb
      assign sel_mask = gmask;
    end

    can_acc_cmp u_cmp (
      .frm_id_i  (frm_id_i),
      .frm_ext_i (frm_ext_i),
      .mb_id_i   (mb_id_i[k*ID_W +: ID_W]),
      .mb_ext_i  (mb_ext_i[k]),
      .mb_en_i   (mb_en_i[k]),
      .mb_rx_i   (mb_rx_i[k]),
      .mask_i    (sel_mask),
      .match_o   (match_vec[k])
    );
  end

  can_acc_prio #(.N(N_MBOX)) u_prio (
    .req_i (match_vec),
    .any_o (any_match),
    .idx_o (win_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q <= 1'b0;
      idx_q <= '0;
    end else begin
      hit_q <= frm_vld_i & any_match;
      if (frm_vld_i) idx_q <= win_idx;
    end
  end

  assign hit_o = hit_q;
  assign idx_o = idx_q;
endmodule

// File: rtl/can_acc_chk.sv
module can_acc_chk #(
  parameter int unsigned N_MBOX = 32,
  localparam int unsigned IDX_W = (N_MBOX > 1) ? $clog2(N_MBOX) : 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              frm_vld_i,
  input logic [N_MBOX-1:0] mb_en_i,
  input logic [N_MBOX-1:0] mb_rx_i,
  input logic [N_MBOX-1:0] match_i,
  input logic              hit_o,
  input logic [IDX_W-1:0]  idx_o
);
  logic              vld_d;
  logic [N_MBOX-1:0] en_d;
  logic [N_MBOX-1:0] rx_d;
  logic [N_MBOX-1:0] match_d;
  logic [N_MBOX-1:0] below_m;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_d   <= 1'b0;
      en_d    <= '0;
      rx_d    <= '0;
      match_d <= '0;
    end else begin
      vld_d   <= frm_vld_i;
      en_d    <= mb_en_i;
      rx_d    <= mb_rx_i;
      match_d <= match_i;
    end
  end

  assign below_m = (N_MBOX'(1) << idx_o) - N_MBOX'(1);

  p_cand_en_rx_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (en_d[idx_o] && rx_d[idx_o]));

  p_lowest_win_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (match_d[idx_o] && ((match_d & below_m) == '0)));

  p_hit_after_vld_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> vld_d);

  p_hit_on_match_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_d && (match_d != '0)) |-> hit_o);

  p_miss_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_d && (match_d == '0)) |-> (!hit_o && idx_o == '0));

  p_idx_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_d |-> $stable(idx_o));
endmodule

bind can_acc_filter can_acc_chk #(.N_MBOX(N_MBOX)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .frm_vld_i (frm_vld_i),
  .mb_en_i   (mb_en_i),
  .mb_rx_i   (mb_rx_i),
  .match_i   (match_vec),
  .hit_o     (hit_o),
  .idx_o     (idx_o)
);

// File: tb/tb_can_acc_filter.sv
`timescale 1ns/1ps
module tb_can_acc_filter;
  localparam int N  = 32;
  localparam int IW = 29;
  localparam int NV = 18;
  localparam logic [28:0] FULL = 29'h1FFF_FFFF;

  typedef struct packed {
    logic [28:0] id;
    logic        ext;
    logic        rtr;
    logic [28:0] gm;
    logic        gx;
    logic [28:0] lm;
    logic        lx;
    logic        hit;
    logic [4:0]  idx;
    logic [3:0]  req;
  } vec_t;

  // mailbox k: base 0x200+k, low bits k, extended when k>=16,
  // mailbox 2 disabled, mailbox 5 transmit
  localparam vec_t VECS [NV] = '{
    '{{11'h201,18'd0},     1'b0,1'b0,FULL,1'b1,FULL,1'b1,1'b1,5'd1, 4'd3}, // R3 exact std
    '{{11'h202,18'd0},     1'b0,1'b0,FULL,1'b1,FULL,1'b1,1'b0,5'd0, 4'd2}, // R2 disabled
    '{{11'h205,18'd0},     1'b0,1'b0,FULL,1'b1,FULL,1'b1,1'b0,5'd0, 4'd2}, // R2 transmit
    '{{11'h211,18'd17},    1'b1,1'b0,FULL,1'b1,FULL,1'b1,1'b1,5'd17,4'd5}, // R5 ext exact
    '{{11'h211,18'd18},    1'b1,1'b0,FULL,1'b1,FULL,1'b1,1'b0,5'd0, 4'd5}, // R5 ext low bits differ
    '{{11'h211,18'h3FFFF}, 1'b0,1'b0,FULL,1'b1,FULL,1'b1,1'b0,5'd0, 4'd6}, // R6 format enforced
    '{{11'h211,18'h3FFFF}, 1'b0,1'b0,FULL,1'b0,FULL,1'b1,1'b1,5'd17,4'd6}, // R6 format ignored, R5
    '{{11'h20E,18'd0},     1'b0,1'b0,{11'h7F8,18'h3FFFF},1'b1,FULL,1'b1,1'b1,5'd8,4'd8}, // R8
    '{{11'h7AB,18'h1234},  1'b1,1'b0,29'h0,1'b0,FULL,1'b1,1'b1,5'd0, 4'd3}, // R3 all don't care
    '{{11'h21F,18'd31},    1'b1,1'b0,FULL,1'b1,FULL,1'b1,1'b1,5'd31,4'd4}, // R4 exact
    '{{11'h21F,18'd99},    1'b1,1'b0,FULL,1'b1,{11'h7FF,18'h0},1'b1,1'b1,5'd31,4'd4}, // R4 local loose
    '{{11'h21F,18'd99},    1'b1,1'b0,{11'h7FF,18'h0},1'b1,FULL,1'b1,1'b0,5'd0,4'd4}, // R4 global ignored
    '{{11'h21F,18'd0},     1'b0,1'b0,FULL,1'b1,FULL,1'b0,1'b1,5'd31,4'd6}, // R6 local fmt off
    '{{11'h21F,18'd0},     1'b0,1'b0,FULL,1'b0,FULL,1'b1,1'b0,5'd0, 4'd6}, // R6 local fmt on
    '{{11'h201,18'd0},     1'b0,1'b1,FULL,1'b1,FULL,1'b1,1'b1,5'd1, 4'd7}, // R7
    '{{11'h202,18'd0},     1'b0,1'b1,FULL,1'b1,FULL,1'b1,1'b0,5'd0, 4'd7}, // R7
    '{{11'h211,18'd17},    1'b1,1'b1,FULL,1'b1,FULL,1'b1,1'b1,5'd17,4'd7}, // R7
    '{{11'h215,18'd0},     1'b0,1'b0,{11'h7F0,18'h3FFFF},1'b0,FULL,1'b1,1'b1,5'd16,4'd8}  // R8
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          frm_vld_i = 1'b0;
  logic [28:0]   frm_id_i = '0;
  logic          frm_ext_i = 1'b0;
  logic          frm_rtr_i = 1'b0;
  logic [N*IW-1:0] mb_id_i;
  logic [N-1:0]  mb_ext_i, mb_en_i, mb_rx_i;
  logic [28:0]   gmask_id_i = FULL, lmask_id_i = FULL;
  logic          gmask_ext_i = 1'b1, lmask_ext_i = 1'b1;
  logic          hit_o;
  logic [4:0]    idx_o;

  int total = 0;
  int bad = 0;

  always #4 clk_i = ~clk_i;

  can_acc_filter #(.N_MBOX(N)) dut (.*);

  task automatic check(input string req, input logic [4:0] eh, input logic [4:0] ah);
    total++;
    if (ah !== eh) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, ah, eh);
    end
  endtask

  task automatic apply(input vec_t v, input logic vld);
    @(negedge clk_i);
    frm_id_i = v.id; frm_ext_i = v.ext; frm_rtr_i = v.rtr;
    gmask_id_i = v.gm; gmask_ext_i = v.gx;
    lmask_id_i = v.lm; lmask_ext_i = v.lx;
    frm_vld_i = vld;
    @(negedge clk_i);
    frm_vld_i = 1'b0;
  endtask

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < N; k++) begin
      mb_id_i[k*IW +: IW] = {11'(12'h200 + k), 18'(k)};
      mb_ext_i[k] = (k >= 16);
      mb_en_i[k]  = (k != 2);
      mb_rx_i[k]  = (k != 5);
    end
    #20;
    check("R1 reset hit", 5'd0, {4'd0, hit_o});
    check("R1 reset idx", 5'd0, idx_o);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 post-release hit", 5'd0, {4'd0, hit_o});

    for (int i = 0; i < NV; i++) begin
      logic [4:0] held;
      apply(VECS[i], 1'b1);
      total++;
      if (hit_o !== VECS[i].hit || idx_o !== VECS[i].idx) begin
        bad++;
        $display("FAIL R%0d vec %0d actual=%0b/%0d expected=%0b/%0d",
                 VECS[i].req, i, hit_o, idx_o, VECS[i].hit, VECS[i].idx);
      end
      held = idx_o;
      @(negedge clk_i);
      check("R9 hit single cycle", 5'd0, {4'd0, hit_o});
      check("R10 idx held", held, idx_o);
    end

    // R9/R10: matching frame without strobe leaves outputs alone
    apply(VECS[9], 1'b1);
    check("R10 setup idx", 5'd31, idx_o);
    apply(VECS[0], 1'b0);
    check("R9 no strobe no hit", 5'd0, {4'd0, hit_o});
    check("R10 no strobe idx", 5'd31, idx_o);

    // R10: miss clears idx
    apply(VECS[1], 1'b1);
    check("R10 miss idx", 5'd0, idx_o);

    // R1: reset mid-run
    apply(VECS[3], 1'b1);
    @(negedge clk_i); rst_ni = 1'b0;
    #1;
    check("R1 mid reset idx", 5'd0, idx_o);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after reset hit", 5'd0, {4'd0, hit_o});

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule